// File: doc/BRIEF.md
# ECC-to-Parity Register Bridge

This block links a system bus that protects 64-bit register data with an 8-bit SEC-DED code to an internal register bus that protects the same data with one even-parity bit per byte. Several downstream chips hold registers on that internal bus. Each downstream chip is selected by a target index that passes through the bridge unchanged.

On a register write, the bridge decodes the incoming code word and fixes any single-bit error. It then drives the data with fresh byte parity toward the selected chip. If the code word is uncorrectable, the bridge inverts every parity bit on purpose. The owning chip then sees a parity error on every byte, logs the error in its own error bit and drops the write. The bridge never blocks a write itself.

On a register read, the bridge checks the byte parity of the data that the chip returns. Clean data is returned on the system bus with a newly generated code. A parity failure turns that data cycle into a default cycle and latches four sticky error flags. Software clears the flags by writing ones.

Top module: `csr_ecc_par_bridge`

## Requirements
- R1: A write presented with `sb_wr_valid` appears on the internal bus one clock later, with `ib_wr_valid` high for that one cycle and `ib_wr_tgt` equal to the presented target index.
- R2: The system-bus code is defined as follows. Data bits 0..63 take the Hamming positions 3, 5, 6, 7, 9, … in increasing order, skipping powers of two. Code bit k (k = 0..6) is the XOR of the data bits whose position has bit k set. Code bit 7 makes the XOR of all 72 bits even. When a write's code word is clean, the data is forwarded unchanged and `ib_wr_par[b]` equals the XOR of data byte b (even parity).
- R3: A write whose code word has exactly one flipped bit, at any of the 72 bit positions, is forwarded with the corrected data and clean byte parity.
- R4: A write whose code word has two flipped bits is forwarded with the received data. All eight parity bits are the inverse of that data's correct byte parity, so the owning target flags a parity error and does not perform the write.
- R5: A read returned with `ib_rd_valid` and correct byte parity appears one clock later with `sb_rd_valid` high, the same data, and `sb_rd_ecc` generated by the R2 code.
- R6: A read returned with any byte parity error produces, one clock later, a single-cycle `sb_rd_dflt` pulse. In that cycle `sb_rd_valid` is low and the data and code outputs are zero.
- R7: A read parity error sets all four bits of `err_flags`. The bits are: bit 0 data-transmit error, bit 1 parity error, bit 2 transmitter-data error, bit 3 internal-bus parity error.
- R8: Each `err_flags` bit stays set until a cycle with `err_clr_valid` high and the matching `err_clr_mask` bit set clears it. If a set and a clear land in the same cycle, the set wins.
- R9: While `rst_n` is low, every output valid, default, data, parity and flag bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sb_wr_valid | input | 1 | System-bus register write strobe |
| sb_wr_data | input | 64 | Write data from the system bus |
| sb_wr_ecc | input | 8 | SEC-DED code for the write data |
| sb_wr_tgt | input | TGT_W | Index of the downstream chip that owns the register |
| ib_wr_valid | output | 1 | Internal-bus write strobe |
| ib_wr_data | output | 64 | Internal-bus write data |
| ib_wr_par | output | 8 | Per-byte even parity, inverted when the code was uncorrectable |
| ib_wr_tgt | output | TGT_W | Target index forwarded to the internal bus |
| ib_rd_valid | input | 1 | Read data from a downstream chip is valid |
| ib_rd_data | input | 64 | Read data from the internal bus |
| ib_rd_par | input | 8 | Per-byte parity of the read data |
| sb_rd_valid | output | 1 | Clean read data is valid on the system bus |
| sb_rd_data | output | 64 | Read data toward the system bus |
| sb_rd_ecc | output | 8 | SEC-DED code for the read data |
| sb_rd_dflt | output | 1 | The read data cycle is defaulted |
| err_clr_valid | input | 1 | Error-flag clear strobe |
| err_clr_mask | input | 4 | Write-one-to-clear mask for the error flags |
| err_flags | output | 4 | Sticky error flags |

## Verification
The assertions check on every cycle the behaviour of the read path and the flags. A clean returned read must reappear one clock later as valid data. A parity-failed read must become a default cycle with zero data and all four flags set. Valid and default are never high together. No flag bit drops unless it was masked for clearing, and no flag rises without a failed read. The write strobe and the target index must also follow the input by one clock.

Only the bench scenarios can show the correctness of the code values:
- single-bit correction at every kind of bit position;
- poisoned parity after double errors, and the way the target model then refuses the write;
- code words generated on reads;
- the set-over-clear ordering when both land in one cycle.

// File: rtl/csr_br_pkg.sv
package csr_br_pkg;
    localparam int DW     = 64;
    localparam int NBYTES = DW / 8;
    localparam int EW     = 8;
    localparam int HW     = EW - 1;
    localparam int LAST_POS = DW + HW;
    localparam int FLAG_W = 4;

    localparam int FLAG_DTE  = 0;
    localparam int FLAG_PAR  = 1;
    localparam int FLAG_TDE  = 2;
    localparam int FLAG_IBPE = 3;

    // Hamming position of data bit idx: non-power-of-two slots from 3 upward
    function automatic logic [HW-1:0] ham_pos(input int idx);
        logic [HW-1:0] r;
        int cnt;
        r = '0;
        cnt = 0;
        for (int p = 3; p <= LAST_POS; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == idx) r = HW'(p);
                cnt++;
            end
        end
        return r;
    endfunction

    function automatic logic [EW-1:0] ecc_gen(input logic [DW-1:0] d);
        logic [EW-1:0] e;
        e = '0;
        for (int i = 0; i < DW; i++) begin
            if (d[i]) e[HW-1:0] = e[HW-1:0] ^ ham_pos(i);
        end
        e[EW-1] = (^d) ^ (^e[HW-1:0]);
        return e;
    endfunction
endpackage

// File: rtl/csr_br_wr_path.sv
module csr_br_wr_path
    import csr_br_pkg::*;
(
    input  logic [DW-1:0]     data_i,
    input  logic [EW-1:0]     ecc_i,
    output logic [DW-1:0]     data_o,
    output logic [NBYTES-1:0] par_o,
    output logic              ue_o
);
    logic [EW-1:0] recomputed;
    logic [HW-1:0] syndrome;
    logic          odd_total;
    logic [DW-1:0] fixed;

    assign recomputed = ecc_gen(data_i);
    assign syndrome   = recomputed[HW-1:0] ^ ecc_i[HW-1:0];
    assign odd_total  = ^{data_i, ecc_i};

    always_comb begin
        fixed = data_i;
        if (odd_total) begin
            for (int i = 0; i < DW; i++) begin
                if (ham_pos(i) == syndrome) fixed[i] = ~data_i[i];
            end
        end
    end

    // even overall parity with a nonzero syndrome means two flips;
    // odd overall parity pointing past the last position is also fatal
    assign ue_o   = (!odd_total && (syndrome != '0)) ||
                    (odd_total && (int'(syndrome) > LAST_POS));
    assign data_o = fixed;

    for (genvar b = 0; b < NBYTES; b++) begin : g_par
        assign par_o[b] = (^fixed[b*8 +: 8]) ^ ue_o;
    end
endmodule

// File: rtl/csr_br_rd_path.sv
module csr_br_rd_path
    import csr_br_pkg::*;
(
    input  logic [DW-1:0]     data_i,
    input  logic [NBYTES-1:0] par_i,
    output logic              ok_o,
    output logic [EW-1:0]     ecc_o
);
    logic [NBYTES-1:0] byte_bad;

    for (genvar b = 0; b < NBYTES; b++) begin : g_chk
        assign byte_bad[b] = ^{data_i[b*8 +: 8], par_i[b]};
    end

    assign ok_o  = ~|byte_bad;
    assign ecc_o = ecc_gen(data_i);
endmodule

// File: rtl/csr_ecc_par_bridge.sv
module csr_ecc_par_bridge
    import csr_br_pkg::*;
#(
    parameter int TGT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sb_wr_valid,
    input  logic [63:0]       sb_wr_data,
    input  logic [7:0]        sb_wr_ecc,
    input  logic [TGT_W-1:0]  sb_wr_tgt,
    output logic              ib_wr_valid,
    output logic [63:0]       ib_wr_data,
    output logic [7:0]        ib_wr_par,
    output logic [TGT_W-1:0]  ib_wr_tgt,
    input  logic              ib_rd_valid,
    input  logic [63:0]       ib_rd_data,
    input  logic [7:0]        ib_rd_par,
    output logic              sb_rd_valid,
    output logic [63:0]       sb_rd_data,
    output logic [7:0]        sb_rd_ecc,
    output logic              sb_rd_dflt,
    input  logic              err_clr_valid,
    input  logic [3:0]        err_clr_mask,
    output logic [3:0]        err_flags
);
    typedef struct packed {
        logic              wr_vld;
        logic [DW-1:0]     wr_data;
        logic [NBYTES-1:0] wr_par;
        logic [TGT_W-1:0]  wr_tgt;
        logic              rd_vld;
        logic [DW-1:0]     rd_data;
        logic [EW-1:0]     rd_ecc;
        logic              rd_dflt;
        logic [FLAG_W-1:0] flags;
    } state_t;

    state_t st_d, st_q;

    logic [DW-1:0]     wp_data;
    logic [NBYTES-1:0] wp_par;
    logic              wp_ue;
    logic              rp_ok;
    logic [EW-1:0]     rp_ecc;

    csr_br_wr_path u_wr (
        .data_i (sb_wr_data),
        .ecc_i  (sb_wr_ecc),
        .data_o (wp_data),
        .par_o  (wp_par),
        .ue_o   (wp_ue)
    );

    csr_br_rd_path u_rd (
        .data_i (ib_rd_data),
        .par_i  (ib_rd_par),
        .ok_o   (rp_ok),
        .ecc_o  (rp_ecc)
    );

    always_comb begin
        logic [FLAG_W-1:0] clr;
        logic              rd_fail;
        st_d = st_q;

        st_d.wr_vld = sb_wr_valid;
        if (sb_wr_valid) begin
            st_d.wr_data = wp_data;
            st_d.wr_par  = wp_par;
            st_d.wr_tgt  = sb_wr_tgt;
        end

        rd_fail      = ib_rd_valid && !rp_ok;
        st_d.rd_vld  = ib_rd_valid && rp_ok;
        st_d.rd_dflt = rd_fail;
        st_d.rd_data = st_d.rd_vld ? ib_rd_data : '0;
        st_d.rd_ecc  = st_d.rd_vld ? rp_ecc : '0;

        clr        = err_clr_valid ? err_clr_mask : '0;
        st_d.flags = st_q.flags & ~clr;
        if (rd_fail) begin
            st_d.flags[FLAG_DTE]  = 1'b1;
            st_d.flags[FLAG_PAR]  = 1'b1;
            st_d.flags[FLAG_TDE]  = 1'b1;
            st_d.flags[FLAG_IBPE] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ib_wr_valid = st_q.wr_vld;
    assign ib_wr_data  = st_q.wr_data;
    assign ib_wr_par   = st_q.wr_par;
    assign ib_wr_tgt   = st_q.wr_tgt;
    assign sb_rd_valid = st_q.rd_vld;
    assign sb_rd_data  = st_q.rd_data;
    assign sb_rd_ecc   = st_q.rd_ecc;
    assign sb_rd_dflt  = st_q.rd_dflt;
    assign err_flags   = st_q.flags;
endmodule

// File: rtl/csr_ecc_par_bridge_chk.sv
module csr_ecc_par_bridge_chk #(
    parameter int TGT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sb_wr_valid,
    input logic [TGT_W-1:0] sb_wr_tgt,
    input logic             ib_wr_valid,
    input logic [TGT_W-1:0] ib_wr_tgt,
    input logic             ib_rd_valid,
    input logic [63:0]      ib_rd_data,
    input logic [7:0]       ib_rd_par,
    input logic             sb_rd_valid,
    input logic [63:0]      sb_rd_data,
    input logic [7:0]       sb_rd_ecc,
    input logic             sb_rd_dflt,
    input logic             err_clr_valid,
    input logic [3:0]       err_clr_mask,
    input logic [3:0]       err_flags
);
    logic par_good;
    always_comb begin
        par_good = 1'b1;
        for (int b = 0; b < 8; b++) begin
            if (^{ib_rd_data[b*8 +: 8], ib_rd_par[b]}) par_good = 1'b0;
        end
    end

    logic [3:0] clr_now;
    assign clr_now = err_clr_valid ? err_clr_mask : 4'h0;

    a_r1_wr_follow: assert property (@(posedge clk) disable iff (!rst_n)
        sb_wr_valid |=> ib_wr_valid && (ib_wr_tgt == $past(sb_wr_tgt)));
    a_r1_wr_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sb_wr_valid |=> !ib_wr_valid);
    a_r5_clean_return: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_rd_valid && par_good) |=> sb_rd_valid && !sb_rd_dflt &&
                                      (sb_rd_data == $past(ib_rd_data)));
    a_r6_bad_default: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_rd_valid && !par_good) |=> sb_rd_dflt && !sb_rd_valid);
    a_r6_dflt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sb_rd_valid && sb_rd_dflt));
    a_r6_dflt_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sb_rd_dflt |-> (sb_rd_data == 64'h0) && (sb_rd_ecc == 8'h0));
    a_r7_flags_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_rd_valid && !par_good) |=> (err_flags == 4'hF));
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_flags & ~clr_now) != 4'h0) |=>
        ((($past(err_flags) & ~$past(clr_now)) & ~err_flags) == 4'h0));
    a_r8_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_flags == 4'h0) && !(ib_rd_valid && !par_good)) |=> (err_flags == 4'h0));
endmodule

bind csr_ecc_par_bridge csr_ecc_par_bridge_chk #(.TGT_W(TGT_W)) chk_i (.*);

// File: tb/csr_ecc_par_bridge_tb_top.sv
`timescale 1ns/1ps
module csr_ecc_par_bridge_tb_top;
    localparam int TGT_W = 2;
    localparam int NT = 1 << TGT_W;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             sb_wr_valid;
    logic [63:0]      sb_wr_data;
    logic [7:0]       sb_wr_ecc;
    logic [TGT_W-1:0] sb_wr_tgt;
    logic             ib_wr_valid;
    logic [63:0]      ib_wr_data;
    logic [7:0]       ib_wr_par;
    logic [TGT_W-1:0] ib_wr_tgt;
    logic             ib_rd_valid;
    logic [63:0]      ib_rd_data;
    logic [7:0]       ib_rd_par;
    logic             sb_rd_valid;
    logic [63:0]      sb_rd_data;
    logic [7:0]       sb_rd_ecc;
    logic             sb_rd_dflt;
    logic             err_clr_valid;
    logic [3:0]       err_clr_mask;
    logic [3:0]       err_flags;

    always #10 clk = ~clk;

    csr_ecc_par_bridge #(.TGT_W(TGT_W)) dut_i (.*);

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    logic [3:0]  exp_flags;
    logic [63:0] tgt_reg [NT];
    logic        tgt_pe  [NT];

    function automatic logic [7:0] tb_ecc(input logic [63:0] d);
        logic [7:0] e = '0;
        int idx = 0;
        for (int p = 1; p <= 71; p++) begin
            if ((p & (p - 1)) == 0) continue;
            if (d[idx]) begin
                for (int k = 0; k < 7; k++) if (p[k]) e[k] = ~e[k];
            end
            idx++;
        end
        e[7] = ^{d, e[6:0]};
        return e;
    endfunction

    function automatic logic [7:0] tb_par(input logic [63:0] d);
        logic [7:0] p;
        for (int b = 0; b < 8; b++) p[b] = ^d[b*8 +: 8];
        return p;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive a code word (flip_mask over {ecc,data}) and check forwarding
    task automatic do_write(input logic [63:0] d, input logic [71:0] flips,
                            input logic [TGT_W-1:0] t, input string req);
        logic [71:0] cw;
        logic        ue;
        logic [63:0] exp_d;
        logic [7:0]  exp_p;
        logic [63:0] old;
        cw = {tb_ecc(d), d} ^ flips;
        ue = ($countones(flips) == 2);
        exp_d = ue ? cw[63:0] : d;
        exp_p = tb_par(exp_d) ^ (ue ? 8'hFF : 8'h00);
        @(negedge clk);
        sb_wr_valid = 1'b1;
        sb_wr_data  = cw[63:0];
        sb_wr_ecc   = cw[71:64];
        sb_wr_tgt   = t;
        @(posedge clk);
        @(negedge clk);
        sb_wr_valid = 1'b0;
        check(ib_wr_valid == 1'b1, "R1", "ib_wr_valid", 64'(ib_wr_valid), 64'd1);
        check(ib_wr_tgt == t, "R1", "ib_wr_tgt", 64'(ib_wr_tgt), 64'(t));
        check(ib_wr_data == exp_d, req, "ib_wr_data", ib_wr_data, exp_d);
        check(ib_wr_par == exp_p, req, "ib_wr_par", 64'(ib_wr_par), 64'(exp_p));
        // target model: refuse the write and log on any bad byte
        old = tgt_reg[ib_wr_tgt];
        if (ib_wr_par != tb_par(ib_wr_data)) tgt_pe[ib_wr_tgt] = 1'b1;
        else tgt_reg[ib_wr_tgt] = ib_wr_data;
        if (ue) begin
            check(tgt_pe[t] == 1'b1, "R4", "target parity flag", 64'(tgt_pe[t]), 64'd1);
            check(tgt_reg[t] == old, "R4", "target write blocked", tgt_reg[t], old);
            tgt_pe[t] = 1'b0;
        end else begin
            check(tgt_reg[t] == d, req, "target register", tgt_reg[t], d);
        end
    endtask

    task automatic do_read(input logic [63:0] d, input bit corrupt,
                           input bit with_clr, input logic [3:0] mask);
        logic [71:0] bus;
        int j;
        bus = {tb_par(d), d};
        if (corrupt) begin
            j = $urandom_range(0, 71);
            bus[j] = ~bus[j];
        end
        @(negedge clk);
        ib_rd_valid   = 1'b1;
        ib_rd_data    = bus[63:0];
        ib_rd_par     = bus[71:64];
        err_clr_valid = with_clr;
        err_clr_mask  = mask;
        @(posedge clk);
        @(negedge clk);
        ib_rd_valid   = 1'b0;
        err_clr_valid = 1'b0;
        if (with_clr) exp_flags = exp_flags & ~mask;
        if (corrupt) begin
            exp_flags = 4'hF;
            check(sb_rd_dflt == 1'b1, "R6", "sb_rd_dflt", 64'(sb_rd_dflt), 64'd1);
            check(sb_rd_valid == 1'b0, "R6", "sb_rd_valid", 64'(sb_rd_valid), 64'd0);
            check(sb_rd_data == 64'h0, "R6", "sb_rd_data", sb_rd_data, 64'h0);
        end else begin
            check(sb_rd_valid == 1'b1, "R5", "sb_rd_valid", 64'(sb_rd_valid), 64'd1);
            check(sb_rd_dflt == 1'b0, "R5", "sb_rd_dflt", 64'(sb_rd_dflt), 64'd0);
            check(sb_rd_data == d, "R5", "sb_rd_data", sb_rd_data, d);
            check(sb_rd_ecc == tb_ecc(d), "R5", "sb_rd_ecc", 64'(sb_rd_ecc), 64'(tb_ecc(d)));
        end
        check(err_flags == exp_flags, corrupt ? "R7" : "R8", "err_flags",
              64'(err_flags), 64'(exp_flags));
        @(posedge clk);
        @(negedge clk);
        check(sb_rd_dflt == 1'b0, "R6", "default pulse ended", 64'(sb_rd_dflt), 64'd0);
    endtask

    task automatic do_clear(input logic [3:0] mask);
        @(negedge clk);
        err_clr_valid = 1'b1;
        err_clr_mask  = mask;
        @(posedge clk);
        @(negedge clk);
        err_clr_valid = 1'b0;
        exp_flags = exp_flags & ~mask;
        check(err_flags == exp_flags, "R8", "flags after clear", 64'(err_flags), 64'(exp_flags));
    endtask

    function automatic logic [71:0] one_flip(input int j);
        logic [71:0] m = '0;
        m[j] = 1'b1;
        return m;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        sb_wr_valid = 0; sb_wr_data = '0; sb_wr_ecc = '0; sb_wr_tgt = '0;
        ib_rd_valid = 0; ib_rd_data = '0; ib_rd_par = '0;
        err_clr_valid = 0; err_clr_mask = '0;
        exp_flags = '0;
        for (int i = 0; i < NT; i++) begin tgt_reg[i] = '0; tgt_pe[i] = 1'b0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(ib_wr_valid == 0 && ib_wr_par == 0 && ib_wr_data == 0, "R9",
              "write side at reset", {ib_wr_par, 55'(ib_wr_valid)}, 64'h0);
        check(sb_rd_valid == 0 && sb_rd_dflt == 0 && sb_rd_data == 0 && sb_rd_ecc == 0,
              "R9", "read side at reset", sb_rd_data, 64'h0);
        check(err_flags == 4'h0, "R9", "flags at reset", 64'(err_flags), 64'h0);
        rst_n = 1'b1;

        // R2 clean writes, directed and random
        do_write(64'h0, '0, 2'd0, "R2");
        do_write(64'hFFFF_FFFF_FFFF_FFFF, '0, 2'd3, "R2");
        do_write(64'h0123_4567_89AB_CDEF, '0, 2'd1, "R2");
        // R3 single flips: every code bit, plus edge data bits
        for (int j = 64; j < 72; j++) do_write({$urandom, $urandom}, one_flip(j), 2'(j), "R3");
        do_write({$urandom, $urandom}, one_flip(0), 2'd2, "R3");
        do_write({$urandom, $urandom}, one_flip(63), 2'd1, "R3");
        // R4 double flips
        do_write(64'hDEAD_BEEF_0000_1111, one_flip(0) | one_flip(1), 2'd2, "R4");
        do_write({$urandom, $urandom}, one_flip(70) | one_flip(71), 2'd0, "R4");
        // random mix
        for (int n = 0; n < 60; n++) begin
            int kind = $urandom_range(0, 2);
            int j1 = $urandom_range(0, 71);
            int j2 = (j1 + 1 + $urandom_range(0, 70)) % 72;
            logic [71:0] m = (kind == 0) ? 72'h0 :
                             (kind == 1) ? one_flip(j1) : (one_flip(j1) | one_flip(j2));
            do_write({$urandom, $urandom}, m, 2'($urandom_range(0, NT - 1)),
                     (kind == 0) ? "R2" : (kind == 1) ? "R3" : "R4");
        end

        // reads
        do_read(64'h0, 1'b0, 1'b0, 4'h0);
        do_read(64'hA5A5_5A5A_0F0F_F0F0, 1'b0, 1'b0, 4'h0);
        do_read(64'h1234_5678_9ABC_DEF0, 1'b1, 1'b0, 4'h0);       // R6 R7
        do_read({$urandom, $urandom}, 1'b0, 1'b0, 4'h0);          // R8 hold
        do_clear(4'b0101);                                        // R8 partial
        do_clear(4'b0000);
        do_read({$urandom, $urandom}, 1'b1, 1'b1, 4'hF);          // R8 set wins
        do_clear(4'hF);
        for (int n = 0; n < 40; n++) begin
            bit bad = ($urandom_range(0, 3) == 0);
            bit cl  = ($urandom_range(0, 3) == 0);
            do_read({$urandom, $urandom}, bad, cl, 4'($urandom_range(0, 15)));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=hung expected=complete");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule